// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron

This block models one spiking neuron that keeps a signed membrane potential and advances it in discrete time steps. During the integration part of a step, synaptic input events arrive one at a time. Each event names one of three axon classes, and the neuron adds the signed weight it stores for that class to its potential. A single-cycle sync strobe closes the step. On that strobe the neuron compares the summed potential with its threshold. If the potential is strictly greater, it fires a spike and zeroes the potential. The stored leak is then added, and the potential is clipped so that it never ends a step negative.

Spikes are evaluated only on the sync strobe, after every input of the step has been summed, so the order of the inputs within a step cannot change the outcome. A small write port loads the three weights, the leak and the threshold. The potential is available as an output so that an enclosing core can observe the neuron's state.

Top module: `lifNeuron`

## Requirements
- R1: After reset the potential is 0, spikeOut is 0, all three weights and the leak are 0, and the threshold is 256.
- R2: A write with cfgWe high stores the low 9 bits of cfgData as follows: cfgSel 0, 1 and 2 set the signed weights of classes 0, 1 and 2; cfgSel 3 sets the signed leak; cfgSel 4 sets the unsigned threshold (1 to 256). Any other cfgSel value changes nothing. A written value takes effect from the next cycle.
- R3: An input event (evValid high, syncPulse low) with evType 0, 1 or 2 adds that class's weight to the potential, and the new value is visible on the next cycle.
- R4: An input event with evType 3 leaves the potential unchanged.
- R5: On a sync cycle in which the potential is strictly greater than the threshold, spikeOut is high in the following cycle. The potential becomes 0 plus the leak, clipped at zero.
- R6: On a sync cycle in which the potential is at or below the threshold, no spike is produced, and the potential becomes its old value plus the leak.
- R7: The potential may go negative while inputs are being summed. At the end of every sync cycle a negative result is forced to 0.
- R8: The potential seen at a sync does not depend on the order of the events in that step.
- R9: Summing saturates at the signed limits of the POT_W-bit potential instead of wrapping around.
- R10: An event that coincides with a sync is held and added in the cycle after the sync. If another event arrives in that cycle, both are added together. Sync pulses are at least two cycles apart.
- R11: spikeOut is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Parameter write strobe |
| cfgSel | input | 3 | Parameter selector |
| cfgData | input | 9 | Parameter value |
| evValid | input | 1 | Synaptic input event strobe |
| evType | input | 2 | Axon class of the event |
| syncPulse | input | 1 | End-of-step strobe |
| spikeOut | output | 1 | Single-cycle spike |
| potential | output | POT_W | Signed membrane potential |

## Verification
The bench builds the neuron with POT_W set to 12. With that width, about ten full-scale events reach either rail, so both saturation limits can be exercised in a short run. Weight, leak and threshold widths stay at their defaults. This keeps the full threshold range reachable, including the boundary cases where the potential equals 256 and 257 and where the threshold is 1.

// File: rtl/lif_pkg.sv
package lif_pkg;
  typedef struct packed {
    logic       takeA;   // held event from a sync cycle
    logic [1:0] typeA;
    logic       takeB;   // event arriving this cycle
    logic [1:0] typeB;
    logic       doSync;  // end-of-step evaluation
  } ctrlStrobe_t;
endpackage

// File: rtl/lifControl.sv
module lifControl
  import lif_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evValid,
  input  logic [1:0]  evType,
  input  logic        syncPulse,
  output ctrlStrobe_t strobe
);
  logic       pendR;
  logic [1:0] pendTypeR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendR     <= 1'b0;
      pendTypeR <= 2'd0;
    end else begin
      pendR     <= syncPulse && evValid;
      pendTypeR <= evType;
    end
  end

  always_comb begin
    strobe.doSync = syncPulse;
    strobe.takeA  = pendR && !syncPulse;
    strobe.typeA  = pendTypeR;
    strobe.takeB  = evValid && !syncPulse;
    strobe.typeB  = evType;
  end

  // R10
  hold_to_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncPulse && evValid) |=> (strobe.takeA && strobe.typeA == $past(evType)));

  // R10
  pend_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendR |=> !pendR);
endmodule

// File: rtl/lifDatapath.sv
module lifDatapath
  import lif_pkg::*;
#(
  parameter int POT_W = 20,
  parameter int WGT_W = 9,
  parameter int THR_W = 9,
  parameter int SEL_W = 3
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [SEL_W-1:0]        cfgSel,
  input  logic [WGT_W-1:0]        cfgData,
  input  ctrlStrobe_t             strobe,
  output logic                    spikeOut,
  output logic signed [POT_W-1:0] potential
);
  localparam int NUM_TYPES = 3;
  localparam int SUM_W     = POT_W + 2;
  localparam logic signed [SUM_W-1:0] P_MAX = {3'b000, {(POT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] P_MIN = {3'b111, {(POT_W-1){1'b0}}};
  localparam logic [THR_W-1:0] THR_RESET = THR_W'(256);

  logic signed [WGT_W-1:0] synW [NUM_TYPES];
  logic signed [WGT_W-1:0] leakR;
  logic        [THR_W-1:0] thrR;
  logic signed [POT_W-1:0] potR;
  logic                    spikeR;

  for (genvar g = 0; g < NUM_TYPES; g++) begin : gWeight
    always_ff @(posedge clk) begin
      if (!rstN)                                   synW[g] <= '0;
      else if (cfgWe && cfgSel == SEL_W'(g))       synW[g] <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leakR <= '0;
      thrR  <= THR_RESET;
    end else if (cfgWe) begin
      if (cfgSel == SEL_W'(3)) leakR <= cfgData;
      if (cfgSel == SEL_W'(4)) thrR  <= cfgData[THR_W-1:0];
    end
  end

  function automatic logic signed [SUM_W-1:0] extW(input logic signed [WGT_W-1:0] w);
    return {{(SUM_W-WGT_W){w[WGT_W-1]}}, w};
  endfunction

  function automatic logic signed [POT_W-1:0] satPot(input logic signed [SUM_W-1:0] x);
    if (x > P_MAX)      return P_MAX[POT_W-1:0];
    else if (x < P_MIN) return P_MIN[POT_W-1:0];
    else                return x[POT_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] potExt, thrExt, wA, wB, intSum, syncBase, syncSum;
  logic signed [POT_W-1:0] intNext, syncNext;
  logic                    fired;

  always_comb begin
    potExt   = {{(SUM_W-POT_W){potR[POT_W-1]}}, potR};
    thrExt   = {{(SUM_W-THR_W){1'b0}}, thrR};
    wA       = (strobe.takeA && strobe.typeA != 2'd3) ? extW(synW[strobe.typeA]) : '0;
    wB       = (strobe.takeB && strobe.typeB != 2'd3) ? extW(synW[strobe.typeB]) : '0;
    intSum   = potExt + wA + wB;
    intNext  = satPot(intSum);
    fired    = potExt > thrExt;
    syncBase = fired ? '0 : potExt;
    syncSum  = syncBase + extW(leakR);
    syncNext = (syncSum < 0) ? '0 : satPot(syncSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      potR   <= '0;
      spikeR <= 1'b0;
    end else begin
      spikeR <= strobe.doSync && fired;
      if (strobe.doSync)                     potR <= syncNext;
      else if (strobe.takeA || strobe.takeB) potR <= intNext;
    end
  end

  assign spikeOut  = spikeR;
  assign potential = potR;

  // R5
  spike_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> $past(strobe.doSync));

  // R7
  clip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.doSync) |-> !potR[POT_W-1]);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doSync || strobe.takeA || strobe.takeB) |=> $stable(potR));

  // R11
  single_spike_chk: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |=> !spikeOut);
endmodule

// File: rtl/lifNeuron.sv
module lifNeuron
  import lif_pkg::*;
#(
  parameter int POT_W = 20,
  parameter int WGT_W = 9,
  parameter int THR_W = 9,
  parameter int SEL_W = 3
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [SEL_W-1:0]        cfgSel,
  input  logic [WGT_W-1:0]        cfgData,
  input  logic                    evValid,
  input  logic [1:0]              evType,
  input  logic                    syncPulse,
  output logic                    spikeOut,
  output logic signed [POT_W-1:0] potential
);
  ctrlStrobe_t strobe;

  lifControl uCtrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType),
    .syncPulse(syncPulse), .strobe(strobe)
  );

  lifDatapath #(.POT_W(POT_W), .WGT_W(WGT_W), .THR_W(THR_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .strobe(strobe), .spikeOut(spikeOut), .potential(potential)
  );
endmodule

// File: tb/tb_lifNeuron.sv
`timescale 1ns/1ps
module tb_lifNeuron;
  localparam int PW   = 12;
  localparam int PMAX = (1 << (PW-1)) - 1;
  localparam int PMIN = -(1 << (PW-1));

  logic clk = 0, rstN = 0, cfgWe = 0, evValid = 0, syncPulse = 0;
  logic [2:0] cfgSel = 0;
  logic [8:0] cfgData = 0;
  logic [1:0] evType = 0;
  logic spikeOut;
  logic signed [PW-1:0] potential;

  always #2 clk = ~clk;

  lifNeuron #(.POT_W(PW)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .evValid(evValid), .evType(evType), .syncPulse(syncPulse),
    .spikeOut(spikeOut), .potential(potential)
  );

  typedef struct { string tag; int pot; bit spk; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int mPot = 0, mLeak = 0, mThr = 256, mPendT = 0;
  int mw[3] = '{0, 0, 0};
  bit mPend = 0;

  function automatic int satp(int x);
    if (x > PMAX) return PMAX;
    if (x < PMIN) return PMIN;
    return x;
  endfunction

  function automatic int wOf(int t);
    return (t == 3) ? 0 : mw[t];
  endfunction

  task automatic cyc(bit we, int sel, int data, bit ev, int ty, bit sy, string tag);
    int nxt;
    bit sp;
    exp_t e;
    @(negedge clk);
    cfgWe = we; cfgSel = sel[2:0]; cfgData = data[8:0];
    evValid = ev; evType = ty[1:0]; syncPulse = sy;
    sp = 0;
    if (sy) begin
      if (mPot > mThr) begin sp = 1; nxt = 0; end else nxt = mPot;
      nxt = nxt + mLeak;
      if (nxt < 0) nxt = 0;
      nxt = satp(nxt);
      mPend = ev; mPendT = ty;
    end else begin
      nxt = mPot;
      if (mPend) nxt = nxt + wOf(mPendT);
      if (ev) nxt = nxt + wOf(ty);
      nxt = satp(nxt);
      mPend = 0;
    end
    mPot = nxt;
    if (we) begin
      case (sel)
        0, 1, 2: mw[sel] = data;
        3: mLeak = data;
        4: mThr = data & 9'h1FF;
        default: ;
      endcase
    end
    e.tag = tag; e.pot = mPot; e.spk = sp;
    sb.push_back(e);
  endtask

  task automatic idle(string tag);        cyc(0, 0, 0, 0, 0, 0, tag); endtask
  task automatic ev(int t, string tag);   cyc(0, 0, 0, 1, t, 0, tag); endtask
  task automatic sync(string tag);        cyc(0, 0, 0, 0, 0, 1, tag); endtask
  task automatic cfg(int s, int d, string tag); cyc(1, s, d, 0, 0, 0, tag); endtask

  // monitor: compares each result just after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ($signed(potential) != e.pot || spikeOut !== e.spk) begin
        fails++;
        $display("FAIL %s: pot=%0d spike=%0b expected pot=%0d spike=%0b",
                 e.tag, $signed(potential), spikeOut, e.pot, e.spk);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (potential !== '0 || spikeOut !== 1'b0) begin
      fails++;
      $display("FAIL R1: pot=%0d spike=%0b expected pot=0 spike=0", $signed(potential), spikeOut);
    end
    ev(0, "R1 weight zero at reset");
    cfg(0, 128, "R2 write w0");
    cfg(1, 1, "R2 write w1");
    cfg(2, -100, "R2 write w2");
    ev(0, "R3 class0 add");
    ev(0, "R3 class0 add to 256");
    sync("R6 equal to default threshold R1");
    ev(1, "R3 class1 add to 257");
    sync("R5 above threshold fires");
    idle("R11 spike drops");
    ev(3, "R4 class3 ignored");
    ev(2, "R7 negative mid-step");
    ev(0, "R8 order neg-then-pos");
    sync("R8 sync after mixed order");
    ev(0, "R8 order pos-then-neg a");
    ev(2, "R8 order pos-then-neg b");
    cfg(3, -50, "R2 write leak");
    sync("R6 leak applied");
    idle("R11 gap");
    sync("R7 clip to zero");
    cfg(4, 1, "R2 threshold one");
    cfg(5, 77, "R2 bad selector ignored");
    ev(1, "R2 w1 unchanged after bad sel");
    sync("R6 equal threshold one no fire");
    ev(1, "R3 add");
    ev(1, "R3 add");
    sync("R5 fire with threshold one");
    idle("R11 one-cycle spike");
    cyc(0, 0, 0, 1, 0, 1, "R10 event with sync");
    ev(1, "R10 held plus new event");
    idle("R10 settle");
    cfg(3, 0, "R2 leak zero");
    cfg(4, 256, "R2 threshold 256");
    cfg(0, 255, "R2 w0 max");
    for (int i = 0; i < 10; i++) ev(0, "R9 upper saturation");
    sync("R5 fire from rail");
    idle("R11 gap");
    cfg(2, -256, "R2 w2 min");
    for (int i = 0; i < 10; i++) ev(2, "R9 lower saturation");
    sync("R7 clip from lower rail");
    idle("R11 final");
    @(negedge clk);
    cfgWe = 0; evValid = 0; syncPulse = 0;
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule